// File: doc/BRIEF.md
# Serial NOR Flash Start-up Sequencer

This block brings an external serial NOR flash into a known, quad-capable state after chip reset, before any read, program or erase traffic starts. It drives a single-line command port toward a transfer engine. Each command on that port carries an opcode, up to two bytes to write and up to three bytes to read back. The engine performs the command and signals its completion with a one-cycle acknowledge.

The sequencer first reads the three identification bytes and looks them up in a small table of known devices. If there is no match, it builds generic parameters from the identification itself. It then polls until the device is neither busy nor suspended and issues the two-opcode software reset. After a timed recovery wait it switches the serial clock divider to the device's fast setting. It checks the quad-enable bit and writes it in the form that device needs, then closes with write-disable and a final idle poll. When the sequence ends, the block reports completion or a timeout error, whether the device was known, its size as a power of two, and the clock divider in use.

Top module: `flash_bringup_seq`

## Requirements
- R1: The first command after reset is opcode 0x9F with no write bytes and three read bytes. The bytes arrive in the order manufacturer, memory type, capacity, and the first byte received sits in bits 23:16 of the read data.
- R2: An identification found in the device table selects that entry's size, maximum clock, quad-enable mask and status-write form, and known_dev is 1.
- R3: On a table miss, known_dev is 0 and size_log2 equals the capacity byte. The generic device uses mask 0x02, a 48 MHz limit and the two-byte status write. A manufacturer byte of 0xC2 changes the mask to 0x04 and selects the single-status-byte form.
- R4: Opcode 0x05 is repeated until bit 0 of the returned byte is clear. Opcode 0x35 is then repeated until bit 7 is clear.
- R5: Opcode 0x66 is followed by opcode 0x99. The next command is requested no earlier than ceil(CLK_HZ × RST_WAIT_US / 10^6) cycles after the acknowledge of 0x99.
- R6: With a non-zero mask, the quad-enable bit is read with 0x05 for single-status-byte devices and with 0x35 otherwise. With a zero mask no read is made. If the bit is already set, no write is made.
- R7: A clear quad-enable bit causes 0x06 and then one write. Devices with the split flag get 0x31 with one byte equal to the mask. Single-status-byte devices get 0x01 with one byte equal to the mask. All others get 0x01 with the two bytes 0x00 and then the mask.
- R8: The sequence closes with 0x04, then 0x05 repeated until bits 1:0 are both zero. After that, done stays 1 and no further command is requested.
- R9: clk_div is PERIPH_HZ / (SLOW_MHZ × 10^6) − 1 from reset until the reset wait ends. It then becomes PERIPH_HZ / (max MHz × 10^6) − 1, clamped to the range 1 to 255.
- R10: Each poll phase makes at most POLL_LIMIT status reads. If the last allowed read is still busy, error becomes 1, done stays 0 and no further command is requested. If that read shows idle, the sequence continues.
- R11: A command's request, opcode and byte counts are held until its acknowledge, and each acknowledge completes exactly one command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cmd_req | output | 1 | Command pending toward the transfer engine |
| cmd_opcode | output | 8 | Opcode of the pending command |
| cmd_wr_cnt | output | 2 | Number of bytes to write after the opcode (0 to 2) |
| cmd_wr_data | output | 16 | Write bytes, first one in bits 15:8 |
| cmd_rd_cnt | output | 2 | Number of bytes to read back (0 to 3) |
| cmd_ack | input | 1 | One-cycle completion of the pending command |
| cmd_rd_data | input | 24 | Read bytes, first one in bits 23:16, valid with cmd_ack |
| done | output | 1 | Start-up finished successfully |
| error | output | 1 | A status poll ran out of attempts |
| known_dev | output | 1 | Identification matched a table entry |
| size_log2 | output | 8 | Device size as a power of two in bytes |
| clk_div | output | 8 | Serial clock divider currently selected |

## Verification
In a poll phase, the acknowledge of the last allowed status read can bring the idle result in the same cycle that the attempt counter reaches its limit. The bench provokes this by keeping the modelled device busy for exactly POLL_LIMIT − 1 reads, and it requires done without error and the full command sequence. A second run keeps the device busy for good. That run must stop with error after exactly POLL_LIMIT reads, and no command may follow. The reset-recovery wait is judged by comparing the cycle of the 0x99 acknowledge with the cycle in which the next command is taken.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

    typedef struct packed {
        logic [23:0] id;
        logic [7:0]  size_log2;
        logic [7:0]  max_mhz;
        logic [7:0]  qe_mask;
        logic        split_wr;
        logic        one_status;
    } devp_t;

    localparam int NUM_KNOWN = 4;

    localparam logic [7:0] OP_ID    = 8'h9F;
    localparam logic [7:0] OP_RDSR1 = 8'h05;
    localparam logic [7:0] OP_RDSR2 = 8'h35;
    localparam logic [7:0] OP_RSTEN = 8'h66;
    localparam logic [7:0] OP_RST   = 8'h99;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_WRSR2 = 8'h31;

    localparam logic [7:0] GEN_MHZ    = 8'd48;
    localparam logic [7:0] GEN_MASK   = 8'h02;
    localparam logic [7:0] ALT_VENDOR = 8'hC2;
    localparam logic [7:0] ALT_MASK   = 8'h04;

    typedef enum logic [3:0] {
        S_ID, S_WIP, S_SUS, S_RSTEN, S_RST, S_RWAIT, S_QRD,
        S_WREN, S_QWR, S_WRDI, S_FIN, S_DONE, S_ERR
    } st_t;

    // Table of known devices; lower index wins on equal identifications.
    function automatic devp_t known_entry(input int idx);
        devp_t e;
        case (idx)
            0:       e = '{24'hC84015, 8'd21, 8'd104, 8'h02, 1'b0, 1'b0};
            1:       e = '{24'hEF4017, 8'd23, 8'd133, 8'h02, 1'b1, 1'b0};
            2:       e = '{24'hC22817, 8'd23, 8'd8,   8'h40, 1'b0, 1'b1};
            3:       e = '{24'h1F4501, 8'd20, 8'd85,  8'h00, 1'b0, 1'b0};
            default: e = '{24'hFFFFFF, 8'd0,  8'd1,   8'h00, 1'b0, 1'b0};
        endcase
        return e;
    endfunction

    function automatic logic [7:0] calc_div(input logic [31:0] periph_hz,
                                            input logic [7:0]  mhz);
        logic [31:0] step;
        logic [31:0] quo;
        logic [31:0] dm1;
        step = {24'd0, mhz} * 32'd1_000_000;
        quo  = (step == 32'd0) ? 32'd0 : periph_hz / step;
        dm1  = quo - 32'd1;
        if (quo < 32'd2)        return 8'd1;
        else if (quo > 32'd256) return 8'd255;
        else                    return dm1[7:0];
    endfunction

endpackage

// File: rtl/fbs_id_match.sv
module fbs_id_match
    import fbs_pkg::*;
#(
    parameter int NUM_DEV = NUM_KNOWN
) (
    input  logic [23:0] id,
    output logic        hit,
    output devp_t       prm
);
    logic [NUM_DEV-1:0] hit_v;
    devp_t              gen;

    for (genvar i = 0; i < NUM_DEV; i++) begin : g_cmp
        assign hit_v[i] = (known_entry(i).id == id);
    end

    always_comb begin
        gen.id         = id;
        gen.size_log2  = id[7:0];
        gen.max_mhz    = GEN_MHZ;
        gen.qe_mask    = (id[23:16] == ALT_VENDOR) ? ALT_MASK : GEN_MASK;
        gen.split_wr   = 1'b0;
        gen.one_status = (id[23:16] == ALT_VENDOR);
    end

    always_comb begin
        prm = gen;
        for (int i = NUM_DEV - 1; i >= 0; i--) begin
            if (hit_v[i]) prm = known_entry(i);
        end
    end

    assign hit = |hit_v;
endmodule

// File: rtl/fbs_div_calc.sv
module fbs_div_calc
    import fbs_pkg::*;
#(
    parameter int PERIPH_HZ = 120_000_000
) (
    input  logic [7:0] mhz,
    output logic [7:0] div
);
    assign div = calc_div(32'(PERIPH_HZ), mhz);
endmodule

// File: rtl/fbs_wait_timer.sv
module fbs_wait_timer #(
    parameter int CYCLES = 1500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int W = $clog2(CYCLES + 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)                cnt_d = W'(CYCLES);
        else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0) && !load;
endmodule

// File: rtl/flash_bringup_seq.sv
module flash_bringup_seq
    import fbs_pkg::*;
#(
    parameter int CLK_HZ      = 50_000_000,
    parameter int PERIPH_HZ   = 120_000_000,
    parameter int RST_WAIT_US = 30,
    parameter int SLOW_MHZ    = 4,
    parameter int POLL_LIMIT  = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic        cmd_req,
    output logic [7:0]  cmd_opcode,
    output logic [1:0]  cmd_wr_cnt,
    output logic [15:0] cmd_wr_data,
    output logic [1:0]  cmd_rd_cnt,
    input  logic        cmd_ack,
    input  logic [23:0] cmd_rd_data,
    output logic        done,
    output logic        error,
    output logic        known_dev,
    output logic [7:0]  size_log2,
    output logic [7:0]  clk_div
);
    localparam int RST_CYC = int'((longint'(CLK_HZ) * longint'(RST_WAIT_US) + 64'd999_999) / 64'd1_000_000);
    localparam logic [7:0] SLOW_DIV = calc_div(32'(PERIPH_HZ), 8'(SLOW_MHZ));
    localparam int PW = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;

    typedef struct packed {
        st_t          st;
        logic [PW-1:0] polls;
        logic [23:0]  id;
        logic [7:0]   div;
    } regs_t;

    regs_t      q, d;
    devp_t      prm;
    logic       hit;
    logic [7:0] fast_div;
    logic       tmr_load, tmr_exp;
    logic [7:0] rd_byte;
    logic       poll_busy;
    st_t        poll_next;

    fbs_id_match #(.NUM_DEV(NUM_KNOWN)) u_match (
        .id  (q.id),
        .hit (hit),
        .prm (prm)
    );

    fbs_div_calc #(.PERIPH_HZ(PERIPH_HZ)) u_div (
        .mhz (prm.max_mhz),
        .div (fast_div)
    );

    fbs_wait_timer #(.CYCLES(RST_CYC)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .expired (tmr_exp)
    );

    assign rd_byte = cmd_rd_data[23:16];

    // Busy test and successor of the three poll phases.
    always_comb begin
        case (q.st)
            S_WIP:   begin poll_busy = rd_byte[0];    poll_next = S_SUS;   end
            S_SUS:   begin poll_busy = rd_byte[7];    poll_next = S_RSTEN; end
            default: begin poll_busy = |rd_byte[1:0]; poll_next = S_DONE;  end
        endcase
    end

    always_comb begin
        d        = q;
        tmr_load = 1'b0;
        case (q.st)
            S_ID: if (cmd_ack) begin
                d.id = cmd_rd_data;
                d.st = S_WIP;
            end
            S_WIP, S_SUS, S_FIN: if (cmd_ack) begin
                if (!poll_busy) begin
                    d.polls = '0;
                    d.st    = poll_next;
                end else if (q.polls == PW'(POLL_LIMIT - 1)) begin
                    d.st = S_ERR;
                end else begin
                    d.polls = q.polls + 1'b1;
                end
            end
            S_RSTEN: if (cmd_ack) d.st = S_RST;
            S_RST: if (cmd_ack) begin
                tmr_load = 1'b1;
                d.st     = S_RWAIT;
            end
            S_RWAIT: if (tmr_exp) begin
                d.div = fast_div;
                d.st  = (prm.qe_mask == 8'h00) ? S_WRDI : S_QRD;
            end
            S_QRD: if (cmd_ack) begin
                d.st = ((rd_byte & prm.qe_mask) != 8'h00) ? S_WRDI : S_WREN;
            end
            S_WREN: if (cmd_ack) d.st = S_QWR;
            S_QWR:  if (cmd_ack) d.st = S_WRDI;
            S_WRDI: if (cmd_ack) d.st = S_FIN;
            default: d = q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= S_ID;
            q.polls <= '0;
            q.id    <= '0;
            q.div   <= SLOW_DIV;
        end else begin
            q <= d;
        end
    end

    // Command port decode from the current phase.
    always_comb begin
        cmd_req     = 1'b1;
        cmd_opcode  = 8'h00;
        cmd_wr_cnt  = 2'd0;
        cmd_wr_data = 16'h0000;
        cmd_rd_cnt  = 2'd0;
        case (q.st)
            S_ID:    begin cmd_opcode = OP_ID;    cmd_rd_cnt = 2'd3; end
            S_WIP:   begin cmd_opcode = OP_RDSR1; cmd_rd_cnt = 2'd1; end
            S_SUS:   begin cmd_opcode = OP_RDSR2; cmd_rd_cnt = 2'd1; end
            S_RSTEN: cmd_opcode = OP_RSTEN;
            S_RST:   cmd_opcode = OP_RST;
            S_QRD:   begin
                cmd_opcode = prm.one_status ? OP_RDSR1 : OP_RDSR2;
                cmd_rd_cnt = 2'd1;
            end
            S_WREN:  cmd_opcode = OP_WREN;
            S_QWR:   begin
                if (prm.split_wr) begin
                    cmd_opcode  = OP_WRSR2;
                    cmd_wr_cnt  = 2'd1;
                    cmd_wr_data = {prm.qe_mask, 8'h00};
                end else if (prm.one_status) begin
                    cmd_opcode  = OP_WRSR;
                    cmd_wr_cnt  = 2'd1;
                    cmd_wr_data = {prm.qe_mask, 8'h00};
                end else begin
                    cmd_opcode  = OP_WRSR;
                    cmd_wr_cnt  = 2'd2;
                    cmd_wr_data = {8'h00, prm.qe_mask};
                end
            end
            S_WRDI:  cmd_opcode = OP_WRDI;
            S_FIN:   begin cmd_opcode = OP_RDSR1; cmd_rd_cnt = 2'd1; end
            default: cmd_req = 1'b0;
        endcase
    end

    assign done      = (q.st == S_DONE);
    assign error     = (q.st == S_ERR);
    assign known_dev = hit;
    assign size_log2 = prm.size_log2;
    assign clk_div   = q.div;
endmodule

// File: rtl/fbs_chk.sv
module fbs_chk #(
    parameter int CLK_HZ      = 50_000_000,
    parameter int RST_WAIT_US = 30
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_req,
    input logic [7:0] cmd_opcode,
    input logic       cmd_ack,
    input logic       done,
    input logic       error,
    input logic [7:0] clk_div
);
    localparam int RST_CYC = int'((longint'(CLK_HZ) * longint'(RST_WAIT_US) + 64'd999_999) / 64'd1_000_000);
    localparam int GW = $clog2(RST_CYC + 1) + 1;

    logic          armed_q;
    logic [GW-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            gap_q   <= '0;
        end else if (cmd_ack && cmd_opcode == 8'h99) begin
            armed_q <= 1'b1;
            gap_q   <= '0;
        end else if (armed_q && gap_q < GW'(RST_CYC)) begin
            gap_q   <= gap_q + 1'b1;
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req && !cmd_ack |=> cmd_req && $stable(cmd_opcode)); // R11

    AST_END_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error) |-> !cmd_req); // R8

    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error)); // R10

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done); // R8

    AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clk_div != 8'd0); // R9

    AST_RST_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && cmd_req |-> gap_q >= GW'(RST_CYC)); // R5
endmodule

bind flash_bringup_seq fbs_chk #(
    .CLK_HZ      (CLK_HZ),
    .RST_WAIT_US (RST_WAIT_US)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_req    (cmd_req),
    .cmd_opcode (cmd_opcode),
    .cmd_ack    (cmd_ack),
    .done       (done),
    .error      (error),
    .clk_div    (clk_div)
);

// File: tb/flash_bringup_seq_tb.sv
module flash_bringup_seq_tb;
    localparam int PLIM     = 16;
    localparam int EXP_GAP  = 1500;      // 30 us at a 20 ns clock
    localparam logic [7:0] EXP_SLOW = 8'd29; // 120 MHz / 4 MHz - 1

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        cmd_req;
    logic [7:0]  cmd_opcode;
    logic [1:0]  cmd_wr_cnt;
    logic [15:0] cmd_wr_data;
    logic [1:0]  cmd_rd_cnt;
    logic        cmd_ack = 1'b0;
    logic [23:0] cmd_rd_data = 24'h0;
    logic        done, error, known_dev;
    logic [7:0]  size_log2, clk_div;

    flash_bringup_seq #(
        .CLK_HZ(50_000_000), .PERIPH_HZ(120_000_000), .RST_WAIT_US(30),
        .SLOW_MHZ(4), .POLL_LIMIT(PLIM)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_req(cmd_req), .cmd_opcode(cmd_opcode),
        .cmd_wr_cnt(cmd_wr_cnt), .cmd_wr_data(cmd_wr_data), .cmd_rd_cnt(cmd_rd_cnt),
        .cmd_ack(cmd_ack), .cmd_rd_data(cmd_rd_data), .done(done), .error(error),
        .known_dev(known_dev), .size_log2(size_log2), .clk_div(clk_div)
    );

    typedef struct packed {
        logic [23:0] id;
        logic [7:0]  s1, s2, wip, sus;
        logic        known;
        logic [7:0]  size, div, mask;
        logic        split, single;
    } scen_t;

    localparam int NSC = 8;
    localparam scen_t SCEN [NSC] = '{
        '{24'hC84015, 8'h00, 8'h00, 8'd2,  8'd1, 1'b1, 8'd21, 8'd1,  8'h02, 1'b0, 1'b0},
        '{24'hEF4017, 8'h00, 8'h02, 8'd0,  8'd0, 1'b1, 8'd23, 8'd1,  8'h02, 1'b1, 1'b0},
        '{24'hEF4017, 8'h00, 8'h00, 8'd1,  8'd2, 1'b1, 8'd23, 8'd1,  8'h02, 1'b1, 1'b0},
        '{24'hC22817, 8'h00, 8'h00, 8'd0,  8'd0, 1'b1, 8'd23, 8'd14, 8'h40, 1'b0, 1'b1},
        '{24'h1F4501, 8'h00, 8'h00, 8'd3,  8'd0, 1'b1, 8'd20, 8'd1,  8'h00, 1'b0, 1'b0},
        '{24'hEF6018, 8'h00, 8'h00, 8'd0,  8'd0, 1'b0, 8'd24, 8'd1,  8'h02, 1'b0, 1'b0},
        '{24'hC22016, 8'h00, 8'h00, 8'd1,  8'd1, 1'b0, 8'd22, 8'd1,  8'h04, 1'b0, 1'b1},
        '{24'hC84015, 8'h00, 8'h00, 8'd15, 8'd0, 1'b1, 8'd21, 8'd1,  8'h02, 1'b0, 1'b0}
    };

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    always @(posedge clk) cyc++;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_chk++;
            n_err++;
            $display("FAIL R8 watchdog: actual=%0d expected<150000", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    // Flash and transfer-engine model
    logic [23:0] m_id;
    logic [7:0]  m_s1, m_s2, v;
    int          m_wip, m_sus;
    logic        m_wel;
    logic        busy = 1'b0;
    int          lat;
    logic [7:0]  c_op;
    logic [1:0]  c_wc;
    logic [15:0] c_wd;
    logic [7:0]  lg_op [64];
    logic [1:0]  lg_wc [64];
    logic [1:0]  lg_rc [64];
    logic [15:0] lg_wd [64];
    int          lg_cyc [64];
    logic [7:0]  lg_div [64];
    int          n_log = 0;
    int          ack99 = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            cmd_ack = 1'b0;
            busy    = 1'b0;
        end else if (cmd_ack) begin
            cmd_ack     = 1'b0;
            cmd_rd_data = 24'h0;
        end else if (busy) begin
            if (lat > 0) lat--;
            else begin
                cmd_rd_data = 24'h0;
                case (c_op)
                    8'h9F: cmd_rd_data = m_id;
                    8'h05: begin
                        v = {m_s1[7:2], m_wel, (m_wip > 0)};
                        if (m_wip > 0) m_wip--;
                        cmd_rd_data = {v, 16'h0};
                    end
                    8'h35: begin
                        v = {(m_sus > 0), m_s2[6:0]};
                        if (m_sus > 0) m_sus--;
                        cmd_rd_data = {v, 16'h0};
                    end
                    8'h06: m_wel = 1'b1;
                    8'h04: m_wel = 1'b0;
                    8'h01: begin
                        m_s1 = c_wd[15:8];
                        if (c_wc == 2'd2) m_s2 = c_wd[7:0];
                    end
                    8'h31: m_s2 = c_wd[15:8];
                    8'h99: ack99 = cyc;
                    default: ;
                endcase
                busy    = 1'b0;
                cmd_ack = 1'b1;
            end
        end else if (cmd_req) begin
            if (n_log < 64) begin
                lg_op[n_log]  = cmd_opcode;
                lg_wc[n_log]  = cmd_wr_cnt;
                lg_rc[n_log]  = cmd_rd_cnt;
                lg_wd[n_log]  = cmd_wr_data;
                lg_cyc[n_log] = cyc;
                lg_div[n_log] = clk_div;
            end
            n_log++;
            c_op = cmd_opcode;
            c_wc = cmd_wr_cnt;
            c_wd = cmd_wr_data;
            busy = 1'b1;
            lat  = 1;
        end
    end

    // Expected command list
    logic [7:0]  e_op [64];
    logic [1:0]  e_wc [64];
    logic [15:0] e_wd [64];
    int          n_exp;

    task automatic push(input logic [7:0] op, input logic [1:0] wc, input logic [15:0] wd);
        if (n_exp < 64) begin
            e_op[n_exp] = op;
            e_wc[n_exp] = wc;
            e_wd[n_exp] = wd;
        end
        n_exp++;
    endtask

    task automatic build_exp(input scen_t s);
        bit qe;
        n_exp = 0;
        push(8'h9F, 2'd0, 16'h0);
        repeat (int'(s.wip) + 1) push(8'h05, 2'd0, 16'h0);
        repeat (int'(s.sus) + 1) push(8'h35, 2'd0, 16'h0);
        push(8'h66, 2'd0, 16'h0);
        push(8'h99, 2'd0, 16'h0);
        if (s.mask != 8'h00) begin
            push(s.single ? 8'h05 : 8'h35, 2'd0, 16'h0);
            qe = s.single ? ((s.s1 & s.mask) != 0) : ((s.s2 & s.mask) != 0);
            if (!qe) begin
                push(8'h06, 2'd0, 16'h0);
                if (s.split)       push(8'h31, 2'd1, {s.mask, 8'h00});
                else if (s.single) push(8'h01, 2'd1, {s.mask, 8'h00});
                else               push(8'h01, 2'd2, {8'h00, s.mask});
            end
        end
        push(8'h04, 2'd0, 16'h0);
        push(8'h05, 2'd0, 16'h0);
    endtask

    task automatic start_scen(input scen_t s);
        rst_n = 1'b0;
        m_id  = s.id;
        m_s1  = s.s1;
        m_s2  = s.s2;
        m_wip = int'(s.wip);
        m_sus = int'(s.sus);
        m_wel = 1'b0;
        n_log = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 20000 && !(done || error); i++) @(negedge clk);
    endtask

    task automatic run_scen(input scen_t s, input int k);
        int bad;
        int j;
        start_scen(s);
        build_exp(s);
        check(done && !error, "R8", $sformatf("scenario %0d done/error", k), {done, error}, 2'b10);
        // R4 R6 R7 R8 R11: exact command list with write bytes
        bad = -1;
        if (n_log != n_exp) bad = 99;
        else for (int i = 0; i < n_exp; i++) begin
            if (bad < 0 && (lg_op[i] != e_op[i] || lg_wc[i] != e_wc[i] ||
                (e_wc[i] == 2'd1 && lg_wd[i][15:8] != e_wd[i][15:8]) ||
                (e_wc[i] == 2'd2 && lg_wd[i] != e_wd[i]))) bad = i;
        end
        if (bad == 99)
            check(1'b0, "R4,R6,R7,R11", $sformatf("scenario %0d command count", k), n_log, n_exp);
        else if (bad >= 0)
            check(1'b0, "R4,R6,R7,R11", $sformatf("scenario %0d command %0d op/wc/wd", k, bad),
                  {lg_op[bad], 6'd0, lg_wc[bad], lg_wd[bad]}, {e_op[bad], 6'd0, e_wc[bad], e_wd[bad]});
        else
            check(1'b1, "R4,R6,R7,R11", "sequence", 0, 0);
        check(known_dev == s.known, "R2,R3", $sformatf("scenario %0d known_dev", k), known_dev, s.known);
        check(size_log2 == s.size, "R2,R3", $sformatf("scenario %0d size_log2", k), size_log2, s.size);
        check(clk_div == s.div, "R9", $sformatf("scenario %0d fast divider", k), clk_div, s.div);
        j = -1;
        for (int i = 0; i < n_log && i < 63; i++) if (j < 0 && lg_op[i] == 8'h99) j = i;
        if (j < 0 || j + 1 >= n_log) begin
            check(1'b0, "R5", $sformatf("scenario %0d reset pair missing", k), j, 0);
        end else begin
            check(lg_op[j-1] == 8'h66, "R5", $sformatf("scenario %0d 0x66 before 0x99", k), lg_op[j-1], 8'h66);
            check(lg_div[j-1] == EXP_SLOW, "R9", $sformatf("scenario %0d slow divider", k), lg_div[j-1], EXP_SLOW);
            check((lg_cyc[j+1] - ack99) >= EXP_GAP && (lg_cyc[j+1] - ack99) <= EXP_GAP + 4,
                  "R5", $sformatf("scenario %0d reset gap", k), lg_cyc[j+1] - ack99, EXP_GAP);
        end
    endtask

    initial begin
        scen_t s;
        // Reset state
        repeat (2) @(negedge clk);
        check(!done && !error, "R8", "reset done/error", {done, error}, 2'b00);
        check(clk_div == EXP_SLOW, "R9", "reset divider", clk_div, EXP_SLOW);

        // Vector table walk
        for (int k = 0; k < NSC; k++) run_scen(SCEN[k], k);

        // R1: identification command shape (from the last run)
        check(lg_op[0] == 8'h9F && lg_wc[0] == 2'd0 && lg_rc[0] == 2'd3, "R1",
              "first command op/wc/rc", {lg_op[0], lg_wc[0], lg_rc[0]}, {8'h9F, 2'd0, 2'd3});

        // R10: device never leaves busy
        s = SCEN[0];
        s.wip = 8'd200;
        start_scen(s);
        check(error && !done, "R10", "timeout error/done", {error, done}, 2'b10);
        check(n_log == 1 + PLIM, "R10", "status reads before timeout", n_log, 1 + PLIM);
        repeat (100) @(negedge clk);
        check(n_log == 1 + PLIM && !cmd_req, "R10", "quiet after timeout", n_log, 1 + PLIM);
        check(error, "R10", "error held", error, 1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule